// File: doc/BRIEF.md
# Paired RAM Response Comparator Chain

This block judges the outputs of RAMs under self-test without storing any expected data. Two identical RAMs receive the same pattern stream, and one analyzer per RAM pair watches both read words. If the two words differ in any bit while a compare strobe is high, a fault is present in one RAM of that pair, and the analyzer sets a fail flag. The flag stays set until reset, so a single bad read anywhere in a long march sequence is kept.

All analyzers are joined into one serial chain. When the test ends, raising the shift enable turns the fail flags into a shift register. The flags then leave one per clock through a single output pin. For RAMs with no neighbour to compare against, an alternate mode checks each pair's first RAM against an expected word that is applied at the block's edge.

Top module: `pair_ram_ora`

## Requirements
- R1: While `rstN` is low, all fail flags are cleared. After reset, a full readout of the chain gives all zeros.
- R2: In neighbour mode (`expMode`=0), on a rising clock edge with `cmpStrobe`=1 and `shiftEn`=0, the fail flag of pair i is set if its A word differs from its B word in any bit. Pair i uses bits [i*WORD_W +: WORD_W] of `ramDataA` and `ramDataB`.
- R3: A compare in which the two words of a pair are equal leaves that pair's fail flag clear.
- R4: When `cmpStrobe`=0 and `shiftEn`=0, no fail flag changes, even if the words differ.
- R5: Once a fail flag is set, it stays set through any later compares until reset.
- R6: While `shiftEn`=1, each clock edge loads flag 0 from `shiftIn` and loads flag i from flag i-1. Compares are ignored while `shiftEn`=1. A bit applied at `shiftIn` therefore reaches `shiftOut` after NUM_PAIRS edges.
- R7: `shiftOut` always shows the fail flag of the last pair (index NUM_PAIRS-1). A readout therefore delivers pair NUM_PAIRS-1 first and pair 0 last.
- R8: In expected mode (`expMode`=1), each pair's A word is compared against `expWord`, and `ramDataB` has no effect.
- R9: A difference in one bit is detected at every bit position of every pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset; clears all fail flags |
| cmpStrobe | input | 1 | Compare the current read words at this edge |
| shiftEn | input | 1 | Operate the fail flags as a shift register |
| shiftIn | input | 1 | Serial input into pair 0 |
| shiftOut | output | 1 | Serial output; fail flag of the last pair |
| expMode | input | 1 | 1: compare A with `expWord`; 0: compare A with B |
| expWord | input | WORD_W | Expected word used in expected mode |
| ramDataA | input | NUM_PAIRS*WORD_W | Read data of the first RAM of each pair |
| ramDataB | input | NUM_PAIRS*WORD_W | Read data of the second RAM of each pair |

## Verification
The comparator is driven with equal words, words that differ in only one pair, words that differ in several pairs, and words that differ in every bit. The readout must show exactly the pairs that differed, in chain order. A walking single-bit difference across all bit positions shows that no bit of the XOR reduction is missing and that every pair maps to the correct slice. Expected-mode vectors change only the B bus or only the A bus, which shows that the reference word replaces B. Directed cases check stickiness, the masking of compares while the strobe is low or shift is enabled, the serial pass-through order, and clearing by reset.

// File: rtl/pairOraPkg.sv
package pairOraPkg;

  typedef struct packed {
    logic cmpEn;
    logic shiftEn;
    logic useExp;
  } oraStrobe_t;

endpackage

// File: rtl/pair_ora_ctrl.sv
module pair_ora_ctrl
  import pairOraPkg::*;
(
  input  logic       cmpStrobe,
  input  logic       shiftEn,
  input  logic       expMode,
  output oraStrobe_t strb
);

  // Shifting takes priority: a compare never disturbs a readout in progress.
  always_comb begin
    strb.shiftEn = shiftEn;
    strb.cmpEn   = cmpStrobe & ~shiftEn;
    strb.useExp  = expMode;
  end

endmodule

// File: rtl/pair_ora_cell.sv
module pair_ora_cell
  import pairOraPkg::*;
#(
  parameter int WORD_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  oraStrobe_t        strb,
  input  logic [WORD_W-1:0] dataA,
  input  logic [WORD_W-1:0] dataB,
  input  logic [WORD_W-1:0] refWord,
  input  logic              chainIn,
  output logic              failQ
);

  logic [WORD_W-1:0] otherWord;
  logic [WORD_W-1:0] diffBits;
  logic              mismatch;

  always_comb begin
    otherWord = strb.useExp ? refWord : dataB;
    diffBits  = dataA ^ otherWord;
    mismatch  = |diffBits;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      failQ <= 1'b0;
    else if (strb.shiftEn)          failQ <= chainIn;
    else if (strb.cmpEn && mismatch) failQ <= 1'b1;
  end

  // R5
  fail_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (failQ && !strb.shiftEn) |=> failQ);

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.shiftEn && !strb.cmpEn) |=> (failQ == $past(failQ)));

  // R6
  shift_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.shiftEn |=> (failQ == $past(chainIn)));

  // R2
  neighbour_diff_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.cmpEn && !strb.useExp && (dataA != dataB)) |=> failQ);

  // R3
  neighbour_equal_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.cmpEn && !strb.useExp && (dataA == dataB) && !failQ) |=> !failQ);

  // R8
  expect_diff_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.cmpEn && strb.useExp && (dataA != refWord)) |=> failQ);

endmodule

// File: rtl/pair_ora_chain.sv
module pair_ora_chain
  import pairOraPkg::*;
#(
  parameter int NUM_PAIRS = 4,
  parameter int WORD_W    = 4,
  localparam int BUS_W    = NUM_PAIRS * WORD_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  oraStrobe_t        strb,
  input  logic [WORD_W-1:0] expWord,
  input  logic [BUS_W-1:0]  ramDataA,
  input  logic [BUS_W-1:0]  ramDataB,
  input  logic              shiftIn,
  output logic              shiftOut
);

  // chainLink[0] is the external input; chainLink[i+1] is the flag of pair i.
  logic [NUM_PAIRS:0] chainLink;

  assign chainLink[0] = shiftIn;

  for (genvar i = 0; i < NUM_PAIRS; i++) begin : g_pair
    pair_ora_cell #(.WORD_W(WORD_W)) i_cell (
      .clk     (clk),
      .rstN    (rstN),
      .strb    (strb),
      .dataA   (ramDataA[i*WORD_W +: WORD_W]),
      .dataB   (ramDataB[i*WORD_W +: WORD_W]),
      .refWord (expWord),
      .chainIn (chainLink[i]),
      .failQ   (chainLink[i+1])
    );
  end

  assign shiftOut = chainLink[NUM_PAIRS];

endmodule

// File: rtl/pair_ram_ora.sv
module pair_ram_ora
  import pairOraPkg::*;
#(
  parameter int NUM_PAIRS = 4,
  parameter int WORD_W    = 4,
  localparam int BUS_W    = NUM_PAIRS * WORD_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmpStrobe,
  input  logic              shiftEn,
  input  logic              shiftIn,
  output logic              shiftOut,
  input  logic              expMode,
  input  logic [WORD_W-1:0] expWord,
  input  logic [BUS_W-1:0]  ramDataA,
  input  logic [BUS_W-1:0]  ramDataB
);

  oraStrobe_t strb;

  pair_ora_ctrl i_ctrl (
    .cmpStrobe (cmpStrobe),
    .shiftEn   (shiftEn),
    .expMode   (expMode),
    .strb      (strb)
  );

  pair_ora_chain #(.NUM_PAIRS(NUM_PAIRS), .WORD_W(WORD_W)) i_chain (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .expWord  (expWord),
    .ramDataA (ramDataA),
    .ramDataB (ramDataB),
    .shiftIn  (shiftIn),
    .shiftOut (shiftOut)
  );

endmodule

// File: tb/test_pair_ram_ora.sv
module test_pair_ram_ora;

  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;
  localparam int WW = 4;
  localparam int BW = NP * WW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cmpStrobe = 1'b0;
  logic          shiftEn = 1'b0;
  logic          shiftIn = 1'b0;
  logic          shiftOut;
  logic          expMode = 1'b0;
  logic [WW-1:0] expWord = '0;
  logic [BW-1:0] ramDataA = '0;
  logic [BW-1:0] ramDataB = '0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pair_ram_ora #(.NUM_PAIRS(NP), .WORD_W(WW)) i_pair_ram_ora (
    .clk(clk), .rstN(rstN), .cmpStrobe(cmpStrobe), .shiftEn(shiftEn),
    .shiftIn(shiftIn), .shiftOut(shiftOut), .expMode(expMode),
    .expWord(expWord), .ramDataA(ramDataA), .ramDataB(ramDataB)
  );

  // {expMode, expWord[3:0], ramDataA[15:0], ramDataB[15:0], strobe, expectedFlags[3:0]}
  localparam int VW = 1 + 4 + 16 + 16 + 1 + 4;
  localparam logic [VW-1:0] VEC [11] = '{
    {1'b0, 4'h0, 16'h1234, 16'h1234, 1'b1, 4'b0000},  // R3 equal words
    {1'b0, 4'h0, 16'h1234, 16'h1235, 1'b1, 4'b0001},  // R2 pair 0
    {1'b0, 4'h0, 16'hA5C3, 16'h25C3, 1'b1, 4'b1000},  // R2 pair 3
    {1'b0, 4'h0, 16'hFFFF, 16'h0000, 1'b1, 4'b1111},  // R2 all pairs
    {1'b0, 4'h0, 16'hFFFF, 16'h0000, 1'b0, 4'b0000},  // R4 no strobe
    {1'b0, 4'h0, 16'h0F0F, 16'h0E1F, 1'b1, 4'b0110},  // R2 middle pairs
    {1'b0, 4'h0, 16'h8421, 16'h8420, 1'b1, 4'b0001},  // R2 one bit
    {1'b1, 4'h5, 16'h5555, 16'h0000, 1'b1, 4'b0000},  // R8 B ignored
    {1'b1, 4'h5, 16'h5575, 16'h5555, 1'b1, 4'b0010},  // R8 A vs expected
    {1'b1, 4'h0, 16'h8000, 16'h8000, 1'b1, 4'b1000},  // R8 A==B but != exp
    {1'b1, 4'hC, 16'hCCCC, 16'hCCCC, 1'b0, 4'b0000}   // R8 R4 no strobe
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; cmpStrobe = 1'b0; shiftEn = 1'b0; shiftIn = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic doCompare(input logic m, input logic [WW-1:0] e,
                           input logic [BW-1:0] a, input logic [BW-1:0] b,
                           input logic stb);
    @(negedge clk);
    expMode = m; expWord = e; ramDataA = a; ramDataB = b; cmpStrobe = stb;
    @(negedge clk);
    cmpStrobe = 1'b0;
  endtask

  // Shifts the whole chain out; got[i] is the flag of pair i.
  task automatic readChain(output logic [NP-1:0] got);
    for (int k = 0; k < NP; k++) begin
      got[NP-1-k] = shiftOut;
      shiftEn = 1'b1; shiftIn = 1'b0;
      @(negedge clk);
    end
    shiftEn = 1'b0;
  endtask

  initial begin
    logic [NP-1:0] got;
    logic [VW-1:0] v;

    doReset();
    check("R1 shiftOut after reset", 32'(shiftOut), 32'd0);
    readChain(got);
    check("R1 readout after reset", 32'(got), 32'd0);

    // Table of vectors
    for (int n = 0; n < 11; n++) begin
      v = VEC[n];
      doReset();
      doCompare(v[VW-1], v[VW-2 -: 4], v[VW-6 -: 16], v[VW-22 -: 16], v[4]);
      readChain(got);
      check($sformatf("R2/R3/R4/R8 vector %0d", n), 32'(got), 32'(v[3:0]));
    end

    // R9 walking single-bit difference
    for (int b = 0; b < BW; b++) begin
      doReset();
      doCompare(1'b0, 4'h0, BW'(1) << b, '0, 1'b1);
      readChain(got);
      check($sformatf("R9 bit %0d", b), 32'(got), 32'(1) << (b / WW));
    end

    // R5 sticky through later matching compares
    doReset();
    doCompare(1'b0, 4'h0, 16'h0100, 16'h0000, 1'b1);
    doCompare(1'b0, 4'h0, 16'h3333, 16'h3333, 1'b1);
    doCompare(1'b1, 4'h3, 16'h3333, 16'h0000, 1'b1);
    readChain(got);
    check("R5 sticky flag", 32'(got), 32'b0100);

    // R7 shiftOut shows last pair without shifting
    doReset();
    doCompare(1'b0, 4'h0, 16'h1000, 16'h0000, 1'b1);
    check("R7 last pair visible", 32'(shiftOut), 32'd1);
    doReset();
    doCompare(1'b0, 4'h0, 16'h0001, 16'h0000, 1'b1);
    check("R7 first pair not visible", 32'(shiftOut), 32'd0);

    // R6 compares ignored while shifting
    doReset();
    @(negedge clk);
    expMode = 1'b0; ramDataA = 16'hFFFF; ramDataB = 16'h0000;
    cmpStrobe = 1'b1; shiftEn = 1'b1; shiftIn = 1'b0;
    repeat (2) @(negedge clk);
    cmpStrobe = 1'b0; shiftEn = 1'b0;
    readChain(got);
    check("R6 compare masked by shift", 32'(got), 32'd0);

    // R6 serial pass-through: shift in 1,0,1,1 and read back in the same order
    doReset();
    begin
      logic [NP-1:0] pat = 4'b1101;  // pat[0] applied first
      logic [NP-1:0] outBits;
      for (int k = 0; k < NP; k++) begin
        shiftEn = 1'b1; shiftIn = pat[k];
        @(negedge clk);
      end
      for (int k = 0; k < NP; k++) begin
        outBits[k] = shiftOut;
        shiftIn = 1'b0;
        @(negedge clk);
      end
      shiftEn = 1'b0;
      check("R6 serial order", 32'(outBits), 32'(pat));
    end

    // R1 reset clears flags that were set
    doReset();
    doCompare(1'b0, 4'h0, 16'hFFFF, 16'h0000, 1'b1);
    doReset();
    readChain(got);
    check("R1 reset clears set flags", 32'(got), 32'd0);

    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule